// File: doc/BRIEF.md
# Three-Voice Square-Wave Tone Generator

This block makes three square-wave tones. Each voice has its own 12-bit period, a 4-bit level and an enable. A host reaches sixteen 8-bit registers through two narrow ports: an 8-bit data port and a 3-bit command port. To change a register, the host first selects a register number with the select command, then stores the data-port value into it with the write command. Between commands the host parks the command port on the idle code. A clear command sets every register to zero and restarts the tone counters.

Each voice divides the clock by a fixed prescale of 16. It then counts prescaled ticks up to its programmed period, and its square wave changes state each time the count reaches the period. Each output carries the voice's level while the wave is high. It is zero while the wave is low or while the voice is switched off in the mixer register. The register slots for noise, envelope and the spare indices are stored but drive nothing.

Top module: `tonegen_top`

## Requirements
- R1: When the command port first takes code 7, the low 4 bits of the data port become the selected register index. Holding code 7 on later cycles does not reselect.
- R2: When the command port first takes code 6, the data port is stored into the selected register. Holding code 6 stores nothing further, and code 4 (idle) changes no register.
- R3: Command code 0 clears all sixteen registers and the selected index to zero and restarts every voice with its wave low. All outputs read zero on the cycle after the code is applied.
- R4: The period of voice A, B or C is {reg 1, 3 or 5 low 4 bits, reg 0, 2 or 4}. The upper 4 bits written to a coarse register are dropped. With period P, one full output cycle lasts 32*P clock cycles.
- R5: A period of 0 gives the same output cycle as a period of 1, which is 32 clock cycles.
- R6: Registers 8, 9 and 10 hold the level of voices A, B and C in their low 4 bits, where 15 is loudest. An enabled voice outputs that level while its wave is high and 0 while it is low.
- R7: Bits 0, 1 and 2 of register 7 are active-low enables for voices A, B and C. A voice whose bit is 1 outputs 0 at all times.
- R8: Writes to registers 6 and 11 through 15 change neither the level nor the period of any voice output.
- R9: While the reset input is high and after it is released, with no writes yet made, all outputs are 0.
- R10: A period of 0x1E8 gives an output cycle exactly twice as long as a period of 0x0F4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdIn | input | 3 | Command code: 7 select, 6 write, 4 idle, 0 clear |
| dataIn | input | 8 | Register index or register data |
| outA | output | 4 | Voice A gated level |
| outB | output | 4 | Voice B gated level |
| outC | output | 4 | Voice C gated level |

## Verification
The bench uses the default parameters: 8-bit data, 12-bit period, 4-bit level and a prescale of 16. Level and mixer checks use small periods of 2 or 3, so each voice toggles every few dozen cycles and every enable and level combination can be sampled quickly. With the defaults, the 0x0F4 and 0x1E8 periods take 7808 and 15616 cycles, so both can be measured edge to edge within the run.

// File: rtl/tonegen_pkg.sv
package tonegen_pkg;
  localparam logic [2:0] CMD_CLEAR  = 3'd0;
  localparam logic [2:0] CMD_IDLE   = 3'd4;
  localparam logic [2:0] CMD_WRITE  = 3'd6;
  localparam logic [2:0] CMD_SELECT = 3'd7;

  localparam int MIXER_IDX = 7;
  localparam int AMP_BASE  = 8;

  typedef struct packed {
    logic selStrobe;
    logic writeStrobe;
    logic clearStrobe;
  } ctrlStrobes_t;
endpackage

// File: rtl/tonegen_voice.sv
module tonegen_voice #(
  parameter int PERIOD_W = 12,
  parameter int AMP_W    = 4,
  parameter int PRESCALE = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic [PERIOD_W-1:0] period,
  input  logic [AMP_W-1:0]    amp,
  input  logic                enable,
  output logic [AMP_W-1:0]    level
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0]    preCount;
  logic [PERIOD_W-1:0] stepCount;
  logic                wave;
  logic                tick;
  logic [PERIOD_W:0]   effPeriod;
  logic [PERIOD_W:0]   nextStep;
  logic                lastStep;

  assign tick      = (preCount == PRE_LAST);
  assign effPeriod = (period == '0) ? (PERIOD_W+1)'(1) : {1'b0, period};
  assign nextStep  = {1'b0, stepCount} + (PERIOD_W+1)'(1);
  assign lastStep  = (nextStep >= effPeriod);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      preCount  <= '0;
      stepCount <= '0;
      wave      <= 1'b0;
    end else begin
      preCount <= tick ? '0 : preCount + PRE_W'(1);
      if (tick) begin
        if (lastStep) begin
          stepCount <= '0;
          wave      <= ~wave;
        end else begin
          stepCount <= nextStep[PERIOD_W-1:0];
        end
      end
    end
  end

  assign level = (enable && wave) ? amp : '0;
endmodule

// File: rtl/tonegen_ctrl.sv
module tonegen_ctrl
  import tonegen_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cmdIn,
  input  logic [IDX_W-1:0] selData,
  output ctrlStrobes_t     strobes,
  output logic [IDX_W-1:0] selIdx
);
  logic [2:0] prevCmd;

  always_comb begin
    strobes.selStrobe   = (cmdIn == CMD_SELECT) && (prevCmd != CMD_SELECT);
    strobes.writeStrobe = (cmdIn == CMD_WRITE)  && (prevCmd != CMD_WRITE);
    strobes.clearStrobe = (cmdIn == CMD_CLEAR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevCmd <= CMD_IDLE;
      selIdx  <= '0;
    end else begin
      prevCmd <= cmdIn;
      if (strobes.clearStrobe) selIdx <= '0;
      else if (strobes.selStrobe) selIdx <= selData;
    end
  end
endmodule

// File: rtl/tonegen_datapath.sv
module tonegen_datapath
  import tonegen_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int DATA_W    = 8,
  parameter int PERIOD_W  = 12,
  parameter int AMP_W     = 4,
  parameter int PRESCALE  = 16,
  parameter int REG_COUNT = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  ctrlStrobes_t                strobes,
  input  logic [$clog2(REG_COUNT)-1:0] selIdx,
  input  logic [DATA_W-1:0]           dataIn,
  output logic [NUM_CH*AMP_W-1:0]     chanOut,
  output logic [REG_COUNT*DATA_W-1:0] regFlat
);
  localparam int IDX_W    = $clog2(REG_COUNT);
  localparam int COARSE_W = PERIOD_W - DATA_W;

  logic [DATA_W-1:0] regFile [REG_COUNT];

  function automatic logic [DATA_W-1:0] keepBits(input logic [IDX_W-1:0] idx,
                                                 input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] mask;
    mask = '1;
    if ((int'(idx) < 2*NUM_CH) && idx[0])
      mask = DATA_W'((1 << COARSE_W) - 1);
    else if ((int'(idx) >= AMP_BASE) && (int'(idx) < AMP_BASE + NUM_CH))
      mask = DATA_W'((1 << AMP_W) - 1);
    return d & mask;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || strobes.clearStrobe) begin
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
    end else if (strobes.writeStrobe) begin
      regFile[selIdx] <= keepBits(selIdx, dataIn);
    end
  end

  for (genvar r = 0; r < REG_COUNT; r++) begin : g_flat
    assign regFlat[r*DATA_W +: DATA_W] = regFile[r];
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_voice
    logic [PERIOD_W-1:0] chPeriod;
    logic [AMP_W-1:0]    chAmp;
    logic                chEnable;

    assign chPeriod = {regFile[2*ch+1][COARSE_W-1:0], regFile[2*ch]};
    assign chAmp    = regFile[AMP_BASE+ch][AMP_W-1:0];
    assign chEnable = ~regFile[MIXER_IDX][ch];

    tonegen_voice #(
      .PERIOD_W(PERIOD_W),
      .AMP_W   (AMP_W),
      .PRESCALE(PRESCALE)
    ) u_voice (
      .clk    (clk),
      .rst    (rst),
      .restart(strobes.clearStrobe),
      .period (chPeriod),
      .amp    (chAmp),
      .enable (chEnable),
      .level  (chanOut[ch*AMP_W +: AMP_W])
    );
  end
endmodule

// File: rtl/tonegen_top.sv
module tonegen_top
  import tonegen_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PERIOD_W  = 12,
  parameter int AMP_W     = 4,
  parameter int PRESCALE  = 16,
  parameter int REG_COUNT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmdIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [AMP_W-1:0]  outA,
  output logic [AMP_W-1:0]  outB,
  output logic [AMP_W-1:0]  outC
);
  localparam int NUM_CH = 3;
  localparam int IDX_W  = $clog2(REG_COUNT);

  ctrlStrobes_t                strobes;
  logic [IDX_W-1:0]            selIdx;
  logic [NUM_CH*AMP_W-1:0]     chanOut;
  logic [REG_COUNT*DATA_W-1:0] regFlat;

  tonegen_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .cmdIn  (cmdIn),
    .selData(dataIn[IDX_W-1:0]),
    .strobes(strobes),
    .selIdx (selIdx)
  );

  tonegen_datapath #(
    .NUM_CH   (NUM_CH),
    .DATA_W   (DATA_W),
    .PERIOD_W (PERIOD_W),
    .AMP_W    (AMP_W),
    .PRESCALE (PRESCALE),
    .REG_COUNT(REG_COUNT)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .selIdx (selIdx),
    .dataIn (dataIn),
    .chanOut(chanOut),
    .regFlat(regFlat)
  );

  assign outA = chanOut[0*AMP_W +: AMP_W];
  assign outB = chanOut[1*AMP_W +: AMP_W];
  assign outC = chanOut[2*AMP_W +: AMP_W];
endmodule

// File: rtl/tonegen_checker.sv
module tonegen_checker (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   cmdIn,
  input logic [7:0]   dataIn,
  input logic [3:0]   selIdx,
  input logic [127:0] regFlat,
  input logic [3:0]   outA,
  input logic [3:0]   outB,
  input logic [3:0]   outC
);
  AST_SELECT_TAKES_INDEX: assert property (@(posedge clk) disable iff (rst)
    (cmdIn == 3'd7 && $past(cmdIn) != 3'd7) |=> (selIdx == $past(dataIn[3:0]))); // R1

  AST_HELD_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
    (cmdIn == 3'd6 && $past(cmdIn) == 3'd6) |=> $stable(regFlat)); // R2

  AST_IDLE_INERT: assert property (@(posedge clk) disable iff (rst)
    (cmdIn == 3'd4) |=> $stable(regFlat)); // R2

  AST_CLEAR_SILENT: assert property (@(posedge clk) disable iff (rst)
    (cmdIn == 3'd0) |=> (outA == 4'd0 && outB == 4'd0 && outC == 4'd0)); // R3

  AST_LEVEL_A: assert property (@(posedge clk) disable iff (rst)
    (outA != 4'd0) |-> (outA == regFlat[64 +: 4])); // R6

  AST_LEVEL_B: assert property (@(posedge clk) disable iff (rst)
    (outB != 4'd0) |-> (outB == regFlat[72 +: 4])); // R6

  AST_LEVEL_C: assert property (@(posedge clk) disable iff (rst)
    (outC != 4'd0) |-> (outC == regFlat[80 +: 4])); // R6

  AST_MUTED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (regFlat[56] || regFlat[57] || regFlat[58]) |->
      ((!regFlat[56] || outA == 4'd0) && (!regFlat[57] || outB == 4'd0) &&
       (!regFlat[58] || outC == 4'd0))); // R7
endmodule

bind tonegen_top tonegen_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .cmdIn  (cmdIn),
  .dataIn (dataIn),
  .selIdx (selIdx),
  .regFlat(regFlat),
  .outA   (outA),
  .outB   (outB),
  .outC   (outC)
);

// File: tb/tonegen_top_test.sv
`timescale 1ns/1ps
module tonegen_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmdIn = 3'd4;
  logic [7:0] dataIn = 8'd0;
  logic [3:0] outA, outB, outC;

  int checks = 0;
  int errors = 0;
  int mx[3];
  int lowSeen[3];
  int oddSeen[3];

  always #2.5 clk = ~clk;

  tonegen_top uut (
    .clk(clk), .rst(rst), .cmdIn(cmdIn), .dataIn(dataIn),
    .outA(outA), .outB(outB), .outC(outC)
  );

  typedef struct packed {
    logic [7:0] mix;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] c;
    logic [3:0] ea;
    logic [3:0] eb;
    logic [3:0] ec;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{8'hFE, 8'd15,  8'd9,   8'd3,   4'd15, 4'd0,  4'd0},
    '{8'hF8, 8'd15,  8'd9,   8'd3,   4'd15, 4'd9,  4'd3},
    '{8'hFD, 8'd7,   8'd8,   8'd1,   4'd0,  4'd8,  4'd0},
    '{8'hFF, 8'd5,   8'd5,   8'd5,   4'd0,  4'd0,  4'd0},
    '{8'hF8, 8'h1A,  8'h2C,  8'h36,  4'd10, 4'd12, 4'd6}
  };

  function automatic logic [3:0] chOut(int i);
    return (i == 0) ? outA : (i == 1) ? outB : outC;
  endfunction

  task automatic check(bit ok, string tag, int actual, int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic cmdCycle(logic [2:0] c, logic [7:0] d);
    @(negedge clk);
    cmdIn  = c;
    dataIn = d;
  endtask

  task automatic writeReg(logic [7:0] idx, logic [7:0] val);
    cmdCycle(3'd7, idx);
    cmdCycle(3'd4, idx);
    cmdCycle(3'd6, val);
    cmdCycle(3'd4, val);
  endtask

  task automatic observe(int n, int ea, int eb, int ec);
    int ex[3];
    ex[0] = ea; ex[1] = eb; ex[2] = ec;
    for (int i = 0; i < 3; i++) begin mx[i] = 0; lowSeen[i] = 0; oddSeen[i] = 0; end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        if (int'(chOut(i)) > mx[i]) mx[i] = int'(chOut(i));
        if (chOut(i) == 4'd0) lowSeen[i] = 1;
        else if (int'(chOut(i)) != ex[i]) oddSeen[i] = 1;
      end
    end
  endtask

  task automatic waitRise(output int n);
    logic prevHi;
    n = 0;
    prevHi = (outA != 4'd0);
    while (n < 40000) begin
      @(negedge clk);
      n++;
      if (!prevHi && outA != 4'd0) break;
      prevHi = (outA != 4'd0);
    end
  endtask

  task automatic measureA(output int len);
    int skip;
    waitRise(skip);
    waitRise(len);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int lenShort, lenLong, len;
    // R9: reset state
    repeat (4) @(negedge clk);
    check(outA == 0 && outB == 0 && outC == 0, "R9 outputs in reset", {outA, outB, outC}, 0);
    rst = 1'b0;
    observe(60, 0, 0, 0);
    check(mx[0] == 0 && mx[1] == 0 && mx[2] == 0, "R9 outputs after reset",
          mx[0] + mx[1] + mx[2], 0);

    writeReg(8'd0, 8'd2);
    writeReg(8'd2, 8'd2);
    writeReg(8'd4, 8'd2);

    // R6 R7: table of mixer and level settings
    for (int v = 0; v < NVEC; v++) begin
      writeReg(8'd8,  VECS[v].a);
      writeReg(8'd9,  VECS[v].b);
      writeReg(8'd10, VECS[v].c);
      writeReg(8'd7,  VECS[v].mix);
      observe(200, VECS[v].ea, VECS[v].eb, VECS[v].ec);
      check(mx[0] == VECS[v].ea, "R6/R7 voice A peak", mx[0], VECS[v].ea);
      check(mx[1] == VECS[v].eb, "R6/R7 voice B peak", mx[1], VECS[v].eb);
      check(mx[2] == VECS[v].ec, "R6/R7 voice C peak", mx[2], VECS[v].ec);
      check(oddSeen[0] + oddSeen[1] + oddSeen[2] == 0, "R6 only zero or level seen",
            oddSeen[0] + oddSeen[1] + oddSeen[2], 0);
      check(lowSeen[0] + lowSeen[1] + lowSeen[2] == 3, "R6 wave low gives zero",
            lowSeen[0] + lowSeen[1] + lowSeen[2], 3);
    end

    // R4 R10: long periods on voice A
    writeReg(8'd7, 8'hFE);
    writeReg(8'd8, 8'd15);
    writeReg(8'd0, 8'hF4);
    writeReg(8'd1, 8'h00);
    measureA(lenShort);
    check(lenShort == 32 * 244, "R4 period 0x0F4 cycle", lenShort, 32 * 244);
    writeReg(8'd0, 8'hE8);
    writeReg(8'd1, 8'h01);
    measureA(lenLong);
    check(lenLong == 32 * 488, "R4 period 0x1E8 cycle", lenLong, 32 * 488);
    check(lenLong == 2 * lenShort, "R10 double period", lenLong, 2 * lenShort);

    // R4: coarse upper bits dropped
    writeReg(8'd1, 8'hF0);
    writeReg(8'd0, 8'h03);
    measureA(len);
    check(len == 96, "R4 coarse masked", len, 96);

    // R5: period 0 equals period 1
    writeReg(8'd0, 8'h00);
    measureA(len);
    check(len == 32, "R5 period zero", len, 32);
    writeReg(8'd0, 8'h01);
    measureA(len);
    check(len == 32, "R5 period one", len, 32);

    // R8: spare register slots have no effect
    writeReg(8'd0, 8'h03);
    writeReg(8'd6, 8'hFF);
    writeReg(8'd11, 8'hFF);
    writeReg(8'd12, 8'hFF);
    writeReg(8'd13, 8'hFF);
    writeReg(8'd14, 8'hFF);
    writeReg(8'd15, 8'hFF);
    measureA(len);
    check(len == 96, "R8 period unchanged", len, 96);
    observe(200, 15, 0, 0);
    check(mx[0] == 15 && mx[1] == 0 && mx[2] == 0, "R8 levels unchanged",
          mx[0] * 256 + mx[1] * 16 + mx[2], 15 * 256);

    // R1 R2: held select and held write act once
    writeReg(8'd7, 8'hF8);
    cmdCycle(3'd7, 8'd9);
    repeat (3) cmdCycle(3'd7, 8'd10);
    cmdCycle(3'd6, 8'd4);
    repeat (3) cmdCycle(3'd6, 8'd13);
    repeat (2) cmdCycle(3'd4, 8'd13);
    observe(200, 15, 4, 6);
    check(mx[1] == 4, "R2 held write stores once", mx[1], 4);
    check(mx[2] == 6, "R1 held select keeps first index", mx[2], 6);
    check(mx[0] == 15, "R2 idle leaves voice A", mx[0], 15);

    // R3: clear command
    cmdCycle(3'd0, 8'h55);
    cmdCycle(3'd4, 8'h00);
    check(outA == 0 && outB == 0 && outC == 0, "R3 outputs after clear",
          {outA, outB, outC}, 0);
    observe(100, 0, 0, 0);
    check(mx[0] + mx[1] + mx[2] == 0, "R3 levels cleared", mx[0] + mx[1] + mx[2], 0);
    writeReg(8'd8, 8'd7);
    measureA(len);
    check(len == 32, "R3 period cleared to zero", len, 32);
    observe(100, 7, 0, 0);
    check(mx[0] == 7, "R3 mixer cleared enables A", mx[0], 7);

    finishRun();
  end
endmodule